// File: doc/BRIEF.md
# Configuration Store with Security Lock

This block holds the configuration pattern of a small programmable logic model, together with the buried register bank that the pattern configures. A program/verify port lets a programmer write a configuration word at an address and read it back. The stored bits are always presented in full on a flat output that drives the modelled logic. Programming can only move a bit from the erased level (1) to the programmed level (0), so each write is ANDed into the word already stored.

A one-way security bit protects the pattern. Once it is set, every verify read returns the all-programmed word (every bit 0), whatever the array holds. Requests to preload a buried register, or to observe one, are refused with an error pulse and change nothing. While locked, the configuration still drives the logic and the registers still capture functional data. Program writes are still accepted after locking. Only a bulk erase returns the array to all ones and clears the lock.

Top module: `cls_config_store`

## Requirements
- R1: After reset every configuration bit is 1, `locked` is 0, all cells hold 0, and `vfy_valid`, `obs_valid`, `req_err`, `vfy_rdata` and `obs_rdata` are 0.
- R2: A program write ANDs `prog_wdata` into word `prog_addr`. The new word appears on `cfg_bits[prog_addr*DATA_W +: DATA_W]` after the next rising edge. A bit at 0 never returns to 1 except through erase.
- R3: A verify request raises `vfy_valid` for one cycle after the edge. `vfy_rdata` then carries the word at `vfy_addr` as it was before that edge, so a program write in the same cycle is not yet visible. When no verify result is presented, `vfy_rdata` is 0.
- R4: `lock_set` makes `locked` 1 from the next edge. It stays 1 until an erase.
- R5: A verify request made while `locked` is 1 returns all zeros. A request in the same cycle as `lock_set` is not yet masked.
- R6: A preload while unlocked writes `pre_wdata` into cell `pre_idx` and takes priority over a capture in the same cycle. A preload while locked leaves every cell unchanged.
- R7: An observe request raises `obs_valid` for one cycle after the edge. While unlocked it returns cell `obs_idx`; while locked it returns all zeros. When no observe result is presented, `obs_rdata` is 0.
- R8: Program writes are still accepted while locked, and `cfg_bits` always shows the true stored content.
- R9: Erase sets every configuration bit to 1 and clears the lock at the next edge. It overrides a program write or `lock_set` in the same cycle and leaves the cells alone.
- R10: `cell_cap` loads every cell from its slice `cell_d[c*DATA_W +: DATA_W]`, whether or not the store is locked.
- R11: `req_err` pulses one cycle after a preload or observe request made while locked, and never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, loads the blank state |
| erase | input | 1 | Bulk erase: all bits to 1, lock cleared |
| prog_we | input | 1 | Program write strobe |
| prog_addr | input | ADDR_W | Word address for programming |
| prog_wdata | input | DATA_W | Word ANDed into the stored word |
| lock_set | input | 1 | Sets the security bit |
| vfy_re | input | 1 | Verify read request |
| vfy_addr | input | ADDR_W | Word address for verify |
| vfy_valid | output | 1 | Verify result present |
| vfy_rdata | output | DATA_W | Verify result, masked to 0 when locked |
| pre_we | input | 1 | Register preload request |
| pre_idx | input | IDX_W | Cell selected for preload |
| pre_wdata | input | DATA_W | Preload value |
| obs_re | input | 1 | Buried register observe request |
| obs_idx | input | IDX_W | Cell selected for observe |
| obs_valid | output | 1 | Observe result present |
| obs_rdata | output | DATA_W | Observed register, 0 when locked |
| req_err | output | 1 | Refused preload or observe |
| cell_cap | input | 1 | Functional capture of all cells |
| cell_d | input | NCELL*DATA_W | Functional data for the cells |
| cell_q | output | NCELL*DATA_W | Buried register contents |
| cfg_bits | output | 2**ADDR_W*DATA_W | Full configuration pattern for the logic |
| locked | output | 1 | Security bit state |

## Verification
The assertions check on every cycle the properties that hold at all times. Verify and observe results are zero after a locked request. A locked preload leaves the cells stable. Configuration bits never rise except through erase. The lock only falls through erase. The error pulse only follows a locked request. Only the bench's scenarios can show the data-dependent results: AND accumulation of repeated writes, the read-before-write order of a verify in the same cycle as a program write, the one-cycle gap between `lock_set` and masking, preload winning over capture, and erase overriding a same-cycle write. A reference model checks these, first through directed cases and then through seeded random traffic.

// File: rtl/cls_pkg.sv
package cls_pkg;
   typedef enum logic {
      LK_OPEN   = 1'b0,
      LK_SEALED = 1'b1
   } lock_state_e;
endpackage

// File: rtl/cls_cfg_array.sv
module cls_cfg_array #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4,
   localparam int DEPTH = 2 ** ADDR_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    erase,
   input  logic                    prog_we,
   input  logic [ADDR_W-1:0]       prog_addr,
   input  logic [DATA_W-1:0]       prog_wdata,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [DATA_W-1:0]       rd_word,
   output logic [DEPTH*DATA_W-1:0] cfg_bits
);
   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      logic [DATA_W-1:0] word_q;
      logic              hit;
      assign hit = prog_we && (prog_addr == ADDR_W'(w));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '1;
         else if (erase)
            word_q <= '1;
         else if (hit)
            word_q <= word_q & prog_wdata;
      end
      assign cfg_bits[w*DATA_W +: DATA_W] = word_q;
   end

   assign rd_word = cfg_bits[rd_addr*DATA_W +: DATA_W];
endmodule

// File: rtl/cls_lock.sv
module cls_lock
   import cls_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic erase,
   input  logic lock_set,
   output logic locked
);
   lock_state_e state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= LK_OPEN;
      else if (erase)
         state_q <= LK_OPEN;
      else if (lock_set)
         state_q <= LK_SEALED;
   end

   assign locked = (state_q == LK_SEALED);
endmodule

// File: rtl/cls_cell_bank.sv
module cls_cell_bank #(
   parameter int DATA_W = 8,
   parameter int NCELL  = 4,
   localparam int IDX_W = (NCELL > 1) ? $clog2(NCELL) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cap,
   input  logic [NCELL*DATA_W-1:0] cell_d,
   input  logic                    pre_ok,
   input  logic [IDX_W-1:0]        pre_idx,
   input  logic [DATA_W-1:0]       pre_wdata,
   input  logic [IDX_W-1:0]        obs_idx,
   output logic [DATA_W-1:0]       obs_word,
   output logic [NCELL*DATA_W-1:0] cell_q
);
   for (genvar c = 0; c < NCELL; c++) begin : g_cell
      logic [DATA_W-1:0] q;
      logic              sel;
      assign sel = pre_ok && (pre_idx == IDX_W'(c));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (sel)
            q <= pre_wdata;
         else if (cap)
            q <= cell_d[c*DATA_W +: DATA_W];
      end
      assign cell_q[c*DATA_W +: DATA_W] = q;
   end

   if (NCELL == 1) begin : g_single
      logic unused_idx;
      assign unused_idx = ^obs_idx;
      assign obs_word   = cell_q[DATA_W-1:0];
   end else begin : g_multi
      assign obs_word = cell_q[obs_idx*DATA_W +: DATA_W];
   end
endmodule

// File: rtl/cls_readback.sv
module cls_readback #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              locked,
   input  logic              vfy_re,
   input  logic [DATA_W-1:0] vfy_word,
   input  logic              obs_re,
   input  logic [DATA_W-1:0] obs_word,
   input  logic              pre_we,
   output logic              vfy_valid,
   output logic [DATA_W-1:0] vfy_rdata,
   output logic              obs_valid,
   output logic [DATA_W-1:0] obs_rdata,
   output logic              req_err
);
   logic [DATA_W-1:0] vfy_next, obs_next;

   always_comb begin
      vfy_next = '0;
      obs_next = '0;
      if (vfy_re && !locked) vfy_next = vfy_word;
      if (obs_re && !locked) obs_next = obs_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vfy_valid <= 1'b0;
         vfy_rdata <= '0;
         obs_valid <= 1'b0;
         obs_rdata <= '0;
         req_err   <= 1'b0;
      end else begin
         vfy_valid <= vfy_re;
         vfy_rdata <= vfy_next;
         obs_valid <= obs_re;
         obs_rdata <= obs_next;
         req_err   <= locked && (pre_we || obs_re);
      end
   end
endmodule

// File: rtl/cls_config_store.sv
module cls_config_store #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4,
   parameter int NCELL  = 4,
   localparam int DEPTH = 2 ** ADDR_W,
   localparam int IDX_W = (NCELL > 1) ? $clog2(NCELL) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    erase,
   input  logic                    prog_we,
   input  logic [ADDR_W-1:0]       prog_addr,
   input  logic [DATA_W-1:0]       prog_wdata,
   input  logic                    lock_set,
   input  logic                    vfy_re,
   input  logic [ADDR_W-1:0]       vfy_addr,
   output logic                    vfy_valid,
   output logic [DATA_W-1:0]       vfy_rdata,
   input  logic                    pre_we,
   input  logic [IDX_W-1:0]        pre_idx,
   input  logic [DATA_W-1:0]       pre_wdata,
   input  logic                    obs_re,
   input  logic [IDX_W-1:0]        obs_idx,
   output logic                    obs_valid,
   output logic [DATA_W-1:0]       obs_rdata,
   output logic                    req_err,
   input  logic                    cell_cap,
   input  logic [NCELL*DATA_W-1:0] cell_d,
   output logic [NCELL*DATA_W-1:0] cell_q,
   output logic [DEPTH*DATA_W-1:0] cfg_bits,
   output logic                    locked
);
   if (DATA_W < 1) begin : g_bad_data
      $error("cls_config_store: DATA_W must be at least 1");
   end
   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("cls_config_store: ADDR_W must lie in 1..10");
   end
   if (NCELL < 1) begin : g_bad_cell
      $error("cls_config_store: NCELL must be at least 1");
   end

   logic [DATA_W-1:0] vfy_word;
   logic [DATA_W-1:0] obs_word;
   logic              pre_ok;

   assign pre_ok = pre_we && !locked;

   cls_cfg_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_array (
      .clk        (clk),
      .rst_n      (rst_n),
      .erase      (erase),
      .prog_we    (prog_we),
      .prog_addr  (prog_addr),
      .prog_wdata (prog_wdata),
      .rd_addr    (vfy_addr),
      .rd_word    (vfy_word),
      .cfg_bits   (cfg_bits)
   );

   cls_lock i_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .erase    (erase),
      .lock_set (lock_set),
      .locked   (locked)
   );

   cls_cell_bank #(.DATA_W(DATA_W), .NCELL(NCELL)) i_cells (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap       (cell_cap),
      .cell_d    (cell_d),
      .pre_ok    (pre_ok),
      .pre_idx   (pre_idx),
      .pre_wdata (pre_wdata),
      .obs_idx   (obs_idx),
      .obs_word  (obs_word),
      .cell_q    (cell_q)
   );

   cls_readback #(.DATA_W(DATA_W)) i_rdbk (
      .clk       (clk),
      .rst_n     (rst_n),
      .locked    (locked),
      .vfy_re    (vfy_re),
      .vfy_word  (vfy_word),
      .obs_re    (obs_re),
      .obs_word  (obs_word),
      .pre_we    (pre_we),
      .vfy_valid (vfy_valid),
      .vfy_rdata (vfy_rdata),
      .obs_valid (obs_valid),
      .obs_rdata (obs_rdata),
      .req_err   (req_err)
   );
endmodule

// File: rtl/cls_store_chk.sv
module cls_store_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4,
   parameter int NCELL  = 4,
   localparam int DEPTH = 2 ** ADDR_W
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    erase,
   input logic                    lock_set,
   input logic                    vfy_re,
   input logic [DATA_W-1:0]       vfy_rdata,
   input logic                    pre_we,
   input logic                    obs_re,
   input logic [DATA_W-1:0]       obs_rdata,
   input logic                    req_err,
   input logic                    cell_cap,
   input logic [NCELL*DATA_W-1:0] cell_q,
   input logic [DEPTH*DATA_W-1:0] cfg_bits,
   input logic                    locked
);
   assert_vfy_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (vfy_re && locked) |=> (vfy_rdata == '0));

   assert_obs_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (obs_re && locked) |=> (obs_rdata == '0));

   assert_locked_preload_inert_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_we && locked && !cell_cap) |=> $stable(cell_q));

   assert_bits_only_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !erase |=> ((cfg_bits & ~$past(cfg_bits)) == '0));

   assert_erase_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      erase |=> (!locked && (&cfg_bits)));

   assert_lock_one_way_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !erase) |=> locked);

   assert_lock_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_set && !erase) |=> locked);

   assert_err_when_refused_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && (pre_we || obs_re)) |=> req_err);

   assert_no_err_open_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |=> !req_err);
endmodule

bind cls_config_store cls_store_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NCELL(NCELL)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .erase     (erase),
   .lock_set  (lock_set),
   .vfy_re    (vfy_re),
   .vfy_rdata (vfy_rdata),
   .pre_we    (pre_we),
   .obs_re    (obs_re),
   .obs_rdata (obs_rdata),
   .req_err   (req_err),
   .cell_cap  (cell_cap),
   .cell_q    (cell_q),
   .cfg_bits  (cfg_bits),
   .locked    (locked)
);

// File: tb/test_cls_config_store.sv
`timescale 1ns/1ps
module test_cls_config_store;
   localparam int DW  = 8;
   localparam int AW  = 4;
   localparam int NC  = 4;
   localparam int DEP = 2 ** AW;
   localparam int IW  = 2;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                erase, prog_we, lock_set, vfy_re, pre_we, obs_re, cell_cap;
   logic [AW-1:0]       prog_addr, vfy_addr;
   logic [DW-1:0]       prog_wdata, pre_wdata;
   logic [IW-1:0]       pre_idx, obs_idx;
   logic [NC*DW-1:0]    cell_d;
   logic                vfy_valid, obs_valid, req_err, locked;
   logic [DW-1:0]       vfy_rdata, obs_rdata;
   logic [NC*DW-1:0]    cell_q;
   logic [DEP*DW-1:0]   cfg_bits;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [DW-1:0] m_cfg [DEP];
   logic [DW-1:0] m_cell [NC];
   logic          m_lock;
   logic          e_vv, e_ov, e_err;
   logic [DW-1:0] e_vd, e_od;

   always #10 clk = ~clk;

   cls_config_store #(.DATA_W(DW), .ADDR_W(AW), .NCELL(NC)) i_cls_config_store (
      .clk(clk), .rst_n(rst_n), .erase(erase), .prog_we(prog_we),
      .prog_addr(prog_addr), .prog_wdata(prog_wdata), .lock_set(lock_set),
      .vfy_re(vfy_re), .vfy_addr(vfy_addr), .vfy_valid(vfy_valid),
      .vfy_rdata(vfy_rdata), .pre_we(pre_we), .pre_idx(pre_idx),
      .pre_wdata(pre_wdata), .obs_re(obs_re), .obs_idx(obs_idx),
      .obs_valid(obs_valid), .obs_rdata(obs_rdata), .req_err(req_err),
      .cell_cap(cell_cap), .cell_d(cell_d), .cell_q(cell_q),
      .cfg_bits(cfg_bits), .locked(locked)
   );

   task automatic check(input string tag, input string what,
                        input logic [DEP*DW-1:0] act, input logic [DEP*DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      logic [DEP*DW-1:0] ecfg;
      logic [NC*DW-1:0]  ecell;
      for (int w = 0; w < DEP; w++) ecfg[w*DW +: DW] = m_cfg[w];
      for (int c = 0; c < NC; c++) ecell[c*DW +: DW] = m_cell[c];
      check(tag, "cfg_bits", cfg_bits, ecfg);
      check(tag, "locked", locked, m_lock);
      check(tag, "cell_q", cell_q, ecell);
      check(tag, "vfy_valid", vfy_valid, e_vv);
      check(tag, "vfy_rdata", vfy_rdata, e_vd);
      check(tag, "obs_valid", obs_valid, e_ov);
      check(tag, "obs_rdata", obs_rdata, e_od);
      check(tag, "req_err", req_err, e_err);
   endtask

   task automatic idle();
      erase = 0; prog_we = 0; lock_set = 0; vfy_re = 0; pre_we = 0;
      obs_re = 0; cell_cap = 0; prog_addr = '0; vfy_addr = '0;
      prog_wdata = '0; pre_wdata = '0; pre_idx = '0; obs_idx = '0; cell_d = '0;
   endtask

   // Model one edge from current inputs, then compare at the following negedge.
   task automatic run(input string tag);
      e_vv  = vfy_re;
      e_vd  = (vfy_re && !m_lock) ? m_cfg[vfy_addr] : '0;
      e_ov  = obs_re;
      e_od  = (obs_re && !m_lock) ? m_cell[obs_idx] : '0;
      e_err = m_lock && (pre_we || obs_re);
      if (cell_cap) for (int c = 0; c < NC; c++) m_cell[c] = cell_d[c*DW +: DW];
      if (pre_we && !m_lock) m_cell[pre_idx] = pre_wdata;
      if (erase) begin
         for (int w = 0; w < DEP; w++) m_cfg[w] = '1;
         m_lock = 1'b0;
      end else begin
         if (prog_we) m_cfg[prog_addr] = m_cfg[prog_addr] & prog_wdata;
         if (lock_set) m_lock = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      compare_all(tag);
      idle();
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         finish_up();
      end
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd2024);
      idle();
      for (int w = 0; w < DEP; w++) m_cfg[w] = '1;
      for (int c = 0; c < NC; c++) m_cell[c] = '0;
      m_lock = 0; e_vv = 0; e_vd = '0; e_ov = 0; e_od = '0; e_err = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare_all("R1");

      // R2: AND accumulation
      prog_we = 1; prog_addr = 4'd3; prog_wdata = 8'hA5; run("R2");
      prog_we = 1; prog_addr = 4'd3; prog_wdata = 8'h0F; run("R2");
      // R3: verify, then read-before-write in the same cycle
      vfy_re = 1; vfy_addr = 4'd3; run("R3");
      vfy_re = 1; vfy_addr = 4'd7; prog_we = 1; prog_addr = 4'd7; prog_wdata = 8'h3C; run("R3");
      vfy_re = 1; vfy_addr = 4'd7; run("R3");
      // R10, R6, R7: capture, preload priority, observe
      cell_cap = 1; cell_d = 32'h44332211; run("R10");
      cell_cap = 1; cell_d = 32'h88776655; pre_we = 1; pre_idx = 2'd2; pre_wdata = 8'h5A; run("R6");
      obs_re = 1; obs_idx = 2'd2; run("R7");
      // R4/R5: same-cycle verify unmasked, next masked
      lock_set = 1; vfy_re = 1; vfy_addr = 4'd3; run("R4");
      vfy_re = 1; vfy_addr = 4'd3; run("R5");
      // R6/R11: locked preload refused; R7 locked observe
      pre_we = 1; pre_idx = 2'd1; pre_wdata = 8'hEE; run("R11");
      obs_re = 1; obs_idx = 2'd1; run("R7");
      // R10 while locked
      cell_cap = 1; cell_d = 32'hDEADBEEF; run("R10");
      // R8: program while locked
      prog_we = 1; prog_addr = 4'd9; prog_wdata = 8'hF0; run("R8");
      // R9: erase overrides same-cycle write and lock_set
      erase = 1; prog_we = 1; prog_addr = 4'd0; prog_wdata = 8'h00; lock_set = 1; run("R9");
      vfy_re = 1; vfy_addr = 4'd9; run("R9");

      // Seeded random traffic
      for (int i = 0; i < 600; i++) begin
         erase      = ($urandom_range(99) < 2);
         lock_set   = ($urandom_range(99) < 4);
         prog_we    = ($urandom_range(99) < 35);
         prog_addr  = AW'($urandom);
         prog_wdata = DW'($urandom) | DW'($urandom);
         vfy_re     = ($urandom_range(99) < 40);
         vfy_addr   = AW'($urandom);
         pre_we     = ($urandom_range(99) < 20);
         pre_idx    = IW'($urandom);
         pre_wdata  = DW'($urandom);
         obs_re     = ($urandom_range(99) < 25);
         obs_idx    = IW'($urandom);
         cell_cap   = ($urandom_range(99) < 10);
         cell_d     = {$urandom};
         run("R2/R3 random");
      end

      done = 1'b1;
      finish_up();
   end
endmodule